// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block makes the serial clock of an SPI controller from the module clock. Two division schemes are available, and one configuration bit chooses between them. The first is a linear even divider driven by an 8-bit count. The second is a power-of-two divider driven by a 4-bit exponent. The transfer engine raises a run enable for as long as it wants the clock to toggle. While run is low, the serial clock rests at the idle polarity.

The block also gives the shift logic two single-cycle strobes, one for the leading edge and one for the trailing edge. Each strobe is high in the module-clock cycle just before the serial clock changes. The shifter can therefore set up or capture data on the exact cycle that the pin moves. A new divider value written while the clock is running is held back until the current half-period has finished, so no half-period is ever cut short.

None of the ports carry streaming data. All pins are plain control and status levels, and there is no handshake or back-pressure.

Top module: `sclk_divider`

## Requirements
- R1: While rst_n is low, sclk, lead_pulse and trail_pulse are all 0.
- R2: While run_en is low, sclk takes the value of cpol at each clock edge, one cycle after cpol is applied, and neither strobe is raised.
- R3: When div_cfg[12] is 1, the linear mode is used. With N = div_cfg[7:0], every half-period of sclk lasts N+1 module-clock cycles, and div_cfg[11:8] has no effect.
- R4: When div_cfg[12] is 0, the power-of-two mode is used. With E = div_cfg[11:8], every half-period lasts 2^E module-clock cycles, and div_cfg[7:0] has no effect.
- R5: A field value of 0 in either mode gives the fastest setting. At that setting sclk toggles on every module-clock edge, so the module clock is divided by 2.
- R6: The clock edge that first samples run_en high restarts the divider. The first sclk change then comes after one full half-period, counted from that edge.
- R7: lead_pulse or trail_pulse is high for exactly the one cycle before each sclk change. The pulse is high during the cycle whose closing edge changes sclk. sclk does not change in any other running cycle.
- R8: After a start, the strobes alternate, and the first one is lead_pulse, which marks sclk moving away from cpol. The two strobes are never high together.
- R9: A divider change made while running leaves the current half-period at its old length. The new value applies from the next half-period boundary onward.
- R10: Once run_en is low, both strobes are low in that same cycle. sclk returns to cpol at the next edge, and a later start begins again with a leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Keeps the serial clock toggling while high |
| cpol | input | 1 | Idle level of sclk |
| div_cfg | input | 13 | [7:0] linear count, [11:8] power-of-two exponent, [12] mode select (1 = linear) |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | High in the cycle before sclk leaves the idle level |
| trail_pulse | output | 1 | High in the cycle before sclk returns to the idle level |

## Verification
A wrong half-period count or a wrongly latched divider shows at the ports within one half-period. The sclk change arrives on the wrong cycle, and the strobe that should come just before it is missing or comes early. A broken phase bit shows on the very first edge after a start, because the pulse type no longer matches the direction sclk moves. A faulty run or restart path shows as sclk off the cpol level one cycle after run drops, or as a first half-period that is shorter than the later ones.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int LIN_W = 8;
  localparam int EXP_W = 4;
  localparam int CFG_W = LIN_W + EXP_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int HALF_W = (LIN_W > EXP_MAX) ? LIN_W : EXP_MAX;

  typedef enum logic {
    MODE_POW2   = 1'b0,
    MODE_LINEAR = 1'b1
  } div_mode_e;

  typedef struct packed {
    div_mode_e        mode;
    logic [EXP_W-1:0] exp_n;
    logic [LIN_W-1:0] lin_n;
  } div_cfg_t;
endpackage

// File: rtl/sclk_div_decode.sv
module sclk_div_decode
  import sclk_div_pkg::*;
#(
  parameter int LW = LIN_W,
  parameter int EW = EXP_W,
  parameter int HW = HALF_W
) (
  input  logic [LW-1:0] lin_n,
  input  logic [EW-1:0] exp_n,
  input  div_mode_e     mode,
  output logic [HW-1:0] half_m1
);
  // half_m1 is the half-period length minus one, in module-clock cycles
  logic [HW-1:0] lin_len;
  logic [HW-1:0] pow_len;

  generate
    if (HW > LW) begin : g_lin_pad
      assign lin_len = {{(HW-LW){1'b0}}, lin_n};
    end else begin : g_lin_flat
      assign lin_len = lin_n[HW-1:0];
    end
  endgenerate

  assign pow_len = (HW'(1) << exp_n) - HW'(1);

  always_comb begin
    if (mode == MODE_LINEAR) half_m1 = lin_len;
    else                     half_m1 = pow_len;
  end
endmodule

// File: rtl/sclk_div_counter.sv
module sclk_div_counter
  import sclk_div_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [HW-1:0] half_new,
  output logic          active,
  output logic          last
);
  logic [HW-1:0] cnt;
  logic [HW-1:0] half_cur;
  logic          going;

  assign going = run_en && active;
  assign last  = (cnt == half_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      half_cur <= '0;
    end else begin
      active <= run_en;
      if (!going || last) begin
        cnt      <= '0;
        half_cur <= half_new;
      end else begin
        cnt <= cnt + HW'(1);
      end
    end
  end

  // R9: the count never passes the length latched for this half-period
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_cur);

  // R9: the latched length only moves at a boundary or while stopped
  assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (going && !last) |=> $stable(half_cur));

  // R6: a start always begins from a count of zero
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !active) |=> (cnt == '0));
endmodule

// File: rtl/sclk_div_edge.sv
module sclk_div_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic active,
  input  logic last,
  input  logic cpol,
  output logic sclk,
  output logic lead_pulse,
  output logic trail_pulse
);
  logic phase;
  logic boundary;

  assign boundary    = run_en && active && last;
  assign lead_pulse  = boundary && !phase;
  assign trail_pulse = boundary && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk  <= 1'b0;
      phase <= 1'b0;
    end else if (!(run_en && active)) begin
      sclk  <= cpol;
      phase <= 1'b0;
    end else if (boundary) begin
      sclk  <= ~sclk;
      phase <= ~phase;
    end
  end

  // R8: the strobes are never high together
  assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_pulse && trail_pulse));

  // R7: a strobe is followed by an sclk change at the next edge
  assert_pulse_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_pulse || trail_pulse) |=> (sclk != $past(sclk)));

  // R7: a running cycle without a strobe leaves sclk unchanged
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && active && !lead_pulse && !trail_pulse) |=> $stable(sclk));

  // R2: while stopped, sclk follows cpol one cycle later
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (sclk == $past(cpol)));

  // R10: no strobe while run is low
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!lead_pulse && !trail_pulse));
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int LW = LIN_W,
  parameter int EW = EXP_W,
  localparam int CW = LW + EW + 1,
  localparam int EMAX = (1 << EW) - 1,
  localparam int HW = (LW > EMAX) ? LW : EMAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cpol,
  input  logic [CW-1:0] div_cfg,
  output logic          sclk,
  output logic          lead_pulse,
  output logic          trail_pulse
);
  logic [HW-1:0] half_new;
  logic          active;
  logic          last;
  div_mode_e     mode;

  assign mode = div_mode_e'(div_cfg[CW-1]);

  sclk_div_decode #(.LW(LW), .EW(EW), .HW(HW)) u_decode (
    .lin_n   (div_cfg[LW-1:0]),
    .exp_n   (div_cfg[LW+EW-1:LW]),
    .mode    (mode),
    .half_m1 (half_new)
  );

  sclk_div_counter #(.HW(HW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .half_new (half_new),
    .active   (active),
    .last     (last)
  );

  sclk_div_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .active      (active),
    .last        (last),
    .cpol        (cpol),
    .sclk        (sclk),
    .lead_pulse  (lead_pulse),
    .trail_pulse (trail_pulse)
  );
endmodule

// File: tb/test_sclk_divider.sv
`timescale 1ns/100ps
module test_sclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] div_cfg = '0;
  logic        sclk, lead_pulse, trail_pulse;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sclk_divider i_sclk_divider (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cpol(cpol),
    .div_cfg(div_cfg), .sclk(sclk), .lead_pulse(lead_pulse),
    .trail_pulse(trail_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one sample: sclk level and strobe pattern against expectation
  task automatic chk_sample(input string req, input int s, input logic e_sclk,
                            input logic e_lead, input logic e_trail);
    chk(sclk == e_sclk, req, $sformatf("sclk at sample %0d", s), sclk, e_sclk);
    chk(lead_pulse == e_lead, req, $sformatf("lead at sample %0d", s), lead_pulse, e_lead);
    chk(trail_pulse == e_trail, req, $sformatf("trail at sample %0d", s), trail_pulse, e_trail);
  endtask

  // start, follow nhalf half-periods of length h, then stop (R6, R7, R8, R10)
  task automatic run_seq(input string req, input logic [12:0] cfg, input logic pol,
                         input int h, input int nhalf);
    @(negedge clk);
    div_cfg = cfg; cpol = pol;
    @(negedge clk);
    chk(sclk == pol, "R2", "idle level before start", sclk, pol);
    run_en = 1'b1;
    for (int s = 1; s <= h * nhalf; s++) begin
      logic es, el, et;
      @(negedge clk);
      es = pol ^ logic'(((s - 1) / h) % 2);
      el = (s % h == 0) && ((s / h) % 2 == 1);
      et = (s % h == 0) && ((s / h) % 2 == 0);
      chk_sample(req, s, es, el, et);
    end
    @(negedge clk);
    run_en = 1'b0;
    #1;
    chk(!lead_pulse && !trail_pulse, "R10", "strobe after stop", lead_pulse | trail_pulse, 0);
    @(negedge clk);
    chk(sclk == pol, "R10", "sclk back at cpol", sclk, pol);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(!lead_pulse && !trail_pulse, "R1", "strobes in reset", lead_pulse | trail_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle;
    cpol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == 1'b1, "R2", "idle follows cpol=1", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R2", "idle follows cpol=0", sclk, 0);
    chk(!lead_pulse && !trail_pulse, "R2", "no strobe idle", lead_pulse | trail_pulse, 0);
  endtask

  // mid-run divider change: linear 3 -> linear 1 (R9)
  task automatic t_change;
    @(negedge clk);
    div_cfg = {1'b1, 4'h0, 8'd3}; cpol = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    for (int s = 1; s <= 9; s++) begin
      logic es, el, et;
      @(negedge clk);
      if (s == 2) div_cfg = {1'b1, 4'h0, 8'd1};
      es = (s >= 5 && s <= 6) || s == 9;
      el = (s == 4) || (s == 8);
      et = (s == 6);
      chk_sample("R9", s, es, el, et);
    end
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R10", "stop after change", sclk, 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    run_seq("R3", {1'b1, 4'hF, 8'd2}, 1'b0, 3, 4);    // linear N=2, exp field junk
    run_seq("R3", {1'b1, 4'h0, 8'd255}, 1'b1, 256, 3); // linear maximum
    run_seq("R4", {1'b0, 4'd3, 8'hA5}, 1'b0, 8, 4);    // pow2 E=3, lin field junk
    run_seq("R4", {1'b0, 4'd6, 8'h00}, 1'b1, 64, 3);
    run_seq("R5", {1'b1, 4'h7, 8'd0}, 1'b0, 1, 6);     // linear fastest
    run_seq("R5", {1'b0, 4'd0, 8'hFF}, 1'b1, 1, 6);    // pow2 fastest
    run_seq("R6", {1'b1, 4'h0, 8'd4}, 1'b1, 5, 2);     // restart gives full first half
    run_seq("R8", {1'b0, 4'd1, 8'h00}, 1'b0, 2, 6);
    t_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule